// File: doc/BRIEF.md
# Thermometer Scratchpad and Alarm Controller

This block is the function-command layer of a single-wire digital thermometer slave. Once the addressing layer has selected the device, it receives whole command and data bytes, along with single-bit read requests, from a bit-level slave engine. It keeps a nine-byte scratchpad that holds the temperature, the two alarm thresholds, the configuration byte, fixed reserved bytes and a checksum byte.

It starts a conversion on a stubbed sensor and times that conversion from the selected resolution. When the conversion ends it stores the masked result and re-evaluates the alarm flag. It also moves the thresholds and configuration to and from a small nonvolatile shadow model, whose access latency is modelled.

Every transaction on the bus begins with a bus reset indication, which is followed by one command byte. Commands are accepted only while no conversion and no shadow access is in progress.

Top module: `tsense_scratch`

## Requirements
- R1: After `rst`, the temperature bytes read 0550h. `nv_busy` is high while the shadow contents load. When the load is done, the high threshold, low threshold and configuration hold the shadow values (defaults 46h, 0Ah, 7Fh).
- R2: Command 4Eh takes the next three bytes as the high threshold, the low threshold and the configuration, in that order.
- R3: The configuration byte always reads with bit 7 = 0 and bits 4..0 = 1. Only bits 6:5 (the resolution code) can be written.
- R4: After command BEh, each read request returns one bit one cycle later (`rd_valid` high). The bits run from byte 0 to byte 8, LSB first: 0 temp low, 1 temp high, 2 high threshold, 3 low threshold, 4 configuration, 5 = FFh, 6 = 00h, 7 = 10h, 8 = checksum. Any read beyond bit 71, and any read with no read command active, returns 1.
- R5: Byte 8 is the CRC-8 of bytes 0–7 (polynomial x^8+x^5+x^4+1, LSB first, zero start), and it tracks every change to those bytes. Shifting all 72 bits read through the same CRC therefore leaves zero.
- R6: A bus reset ends a read, and the next read starts again at byte 0. A bus reset in the middle of a write keeps the bytes already received and leaves the rest unchanged.
- R7: Command 44h pulses `sens_start` in the cycle after it is accepted. `conv_busy` then stays high for CONV_TICKS>>(3−code) cycles, where code is the resolution code. The sample last delivered with `sens_done` becomes the temperature.
- R8: Resolution code 00, 01 and 10 (9, 10 and 11 bits) clears result bits 2..0, 1..0 and 0 respectively. Code 11 keeps all 16 bits.
- R9: At the end of each conversion, the alarm is set if result bits 11..4, taken as a signed byte, are ≥ the signed high threshold or ≤ the signed low threshold. Otherwise the alarm is cleared.
- R10: Command 48h stores the three programmable bytes in the shadow model, and `nv_busy` is high for NV_TICKS cycles while it does. Command B8h reloads those bytes from the shadow model.
- R11: After B8h, read requests return 0 while the reload is running and 1 once it has finished.
- R12: Command bytes that arrive while a conversion or a shadow access is running are ignored and change no scratchpad byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset seen; ends the transaction |
| byte_valid | input | 1 | A byte from the bit layer is present |
| byte_data | input | 8 | Command or data byte |
| rd_req | input | 1 | Read slot request |
| rd_valid | output | 1 | Read bit valid (one cycle after rd_req) |
| rd_bit | output | 1 | Bit returned for the read slot |
| sens_start | output | 1 | Start pulse to the sensor stub |
| sens_done | input | 1 | Sensor sample valid |
| sens_value | input | 16 | Sensor sample, two's complement, 1/16 degree |
| conv_busy | output | 1 | Conversion in progress |
| nv_busy | output | 1 | Shadow store access in progress |
| alarm | output | 1 | Alarm flag |

## Verification
The bench checks alarm bounds right at the threshold values and with negative thresholds. A design that compared unsigned would raise the alarm for a reading of 24 against a low threshold of −10. A design that compared the upper bits would miss the −128 reading built from bits 11..4.

It sets each resolution code and measures the conversion length and the cleared low bits. Shift or mask errors show up there as a wrong cycle count or as stray low bits.

It cuts a write after one byte and a read after one byte. This catches a design that throws away partial writes or that resumes a read in the middle of the scratchpad.

It sends commands during a conversion and polls a reload. A design that accepts commands while busy would change the thresholds. A design that reports the reload status wrongly would return 1 too early.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam logic [7:0] OP_CONVERT = 8'h44;
    localparam logic [7:0] OP_WRSP    = 8'h4E;
    localparam logic [7:0] OP_RDSP    = 8'hBE;
    localparam logic [7:0] OP_COPY    = 8'h48;
    localparam logic [7:0] OP_RECALL  = 8'hB8;

    localparam int SP_BYTES = 9;
    localparam int SP_BITS  = SP_BYTES * 8;

    typedef struct packed {
        logic [7:0] th;
        logic [7:0] tl;
        logic [7:0] cfg;
    } trip_t;

    typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_HOLD} phase_t;
    typedef enum logic [1:0] {RD_IDLE, RD_DATA, RD_STAT} rdmode_t;
    typedef enum logic {NV_LOAD, NV_STORE} nvop_t;

    // CRC-8, reflected form of x^8+x^5+x^4+1, LSB of the word first
    function automatic logic [7:0] crc8_lsb(input logic [63:0] d);
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = 0; i < 64; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [7:0] cfg_fix(input logic [7:0] v);
        return {1'b0, v[6:5], 5'b11111};
    endfunction

    function automatic logic [15:0] res_mask(input logic [15:0] t, input logic [1:0] r);
        logic [15:0] o;
        case (r)
            2'b00:   o = {t[15:3], 3'b000};
            2'b01:   o = {t[15:2], 2'b00};
            2'b10:   o = {t[15:1], 1'b0};
            default: o = t;
        endcase
        return o;
    endfunction

    function automatic logic alarm_eval(input logic [15:0] t, input logic [7:0] hi,
                                        input logic [7:0] lo);
        logic signed [7:0] v;
        v = $signed(t[11:4]);
        return (v >= $signed(hi)) || (v <= $signed(lo));
    endfunction

endpackage

// File: rtl/tsense_nvm.sv
module tsense_nvm
    import tsense_pkg::*;
#(
    parameter int         NV_TICKS = 8,
    parameter logic [7:0] TH0      = 8'h46,
    parameter logic [7:0] TL0      = 8'h0A,
    parameter logic [7:0] CFG0     = 8'h7F
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  store_req,
    input  trip_t store_data,
    input  logic  load_req,
    output logic  busy,
    output trip_t mem,
    output logic  load_done
);
    localparam int CW = $clog2(NV_TICKS + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    nvop_t         op_q;
    trip_t         pend_q;
    trip_t         mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;               // power-up reload
            cnt_q  <= CW'(NV_TICKS - 1);
            op_q   <= NV_LOAD;
            pend_q <= '0;
            mem_q  <= '{th: TH0, tl: TL0, cfg: cfg_fix(CFG0)};
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                if (op_q == NV_STORE) mem_q <= pend_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (store_req) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(NV_TICKS - 1);
            op_q   <= NV_STORE;
            pend_q <= store_data;
        end else if (load_req) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(NV_TICKS - 1);
            op_q   <= NV_LOAD;
        end
    end

    assign busy      = busy_q;
    assign mem       = mem_q;
    assign load_done = busy_q && (cnt_q == '0) && (op_q == NV_LOAD);

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_q |=> $stable(mem_q));
    assert_nv_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (store_req || load_req) |-> !busy_q);

endmodule

// File: rtl/tsense_conv.sv
module tsense_conv
    import tsense_pkg::*;
#(
    parameter int CONV_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  res,
    input  logic [7:0]  th,
    input  logic [7:0]  tl,
    input  logic        sens_done,
    input  logic [15:0] sens_value,
    output logic        sens_start,
    output logic        busy,
    output logic [15:0] temp,
    output logic        alarm
);
    localparam int CW = $clog2(CONV_TICKS + 1);

    logic          busy_q, start_q, alarm_q;
    logic [CW-1:0] cnt_q, span;
    logic [1:0]    res_q;
    logic [15:0]   pend_q, temp_q, sample, masked;
    logic          commit;

    always_comb begin
        case (res)
            2'b00:   span = CW'(CONV_TICKS / 8);
            2'b01:   span = CW'(CONV_TICKS / 4);
            2'b10:   span = CW'(CONV_TICKS / 2);
            default: span = CW'(CONV_TICKS);
        endcase
    end

    assign sample = sens_done ? sens_value : pend_q;
    assign masked = res_mask(sample, res_q);
    assign commit = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            cnt_q   <= '0;
            res_q   <= 2'b11;
            pend_q  <= 16'h0550;
            temp_q  <= 16'h0550;
            alarm_q <= 1'b0;
        end else begin
            start_q <= start;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= span - 1'b1;
                res_q  <= res;
                pend_q <= temp_q;
            end else if (busy_q) begin
                if (sens_done) pend_q <= sens_value;
                if (commit) begin
                    busy_q  <= 1'b0;
                    temp_q  <= masked;
                    alarm_q <= alarm_eval(masked, th, tl);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign sens_start = start_q;
    assign busy       = busy_q;
    assign temp       = temp_q;
    assign alarm      = alarm_q;

    assert_start_idle_R12: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);
    assert_conv_end_R7: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy_q);
    assert_mask9_R8: assert property (@(posedge clk) disable iff (rst)
        (commit && res_q == 2'b00) |=> (temp_q[2:0] == 3'b000));
    assert_mask10_R8: assert property (@(posedge clk) disable iff (rst)
        (commit && res_q == 2'b01) |=> (temp_q[1:0] == 2'b00));

endmodule

// File: rtl/tsense_rd.sv
module tsense_rd
    import tsense_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_data,
    input  logic               arm_stat,
    input  logic               stop,
    input  logic               stat_bit,
    input  logic               rd_req,
    input  logic [SP_BITS-1:0] image,
    output logic               rd_valid,
    output logic               rd_bit
);
    localparam int IW = $clog2(SP_BITS + 1);

    rdmode_t       mode_q;
    logic [IW-1:0] idx_q;
    logic          valid_q, bit_q, bit_now, in_range;

    assign in_range = (idx_q < IW'(SP_BITS));

    always_comb begin
        case (mode_q)
            RD_DATA: bit_now = in_range ? image[idx_q] : 1'b1;
            RD_STAT: bit_now = stat_bit;
            default: bit_now = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= RD_IDLE;
            idx_q   <= '0;
            valid_q <= 1'b0;
            bit_q   <= 1'b1;
        end else begin
            valid_q <= rd_req;
            if (rd_req) bit_q <= bit_now;
            if (stop) begin
                mode_q <= RD_IDLE;
                idx_q  <= '0;
            end else if (arm_data) begin
                mode_q <= RD_DATA;
                idx_q  <= '0;
            end else if (arm_stat) begin
                mode_q <= RD_STAT;
            end else if (rd_req && mode_q == RD_DATA && in_range) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_bit   = bit_q;

    assert_slot_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    assert_idx_R4: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IW'(SP_BITS));

endmodule

// File: rtl/tsense_scratch.sv
module tsense_scratch
    import tsense_pkg::*;
#(
    parameter int         CONV_TICKS = 64,
    parameter int         NV_TICKS   = 8,
    parameter logic [7:0] NV_TH      = 8'h46,
    parameter logic [7:0] NV_TL      = 8'h0A,
    parameter logic [7:0] NV_CFG     = 8'h7F,
    parameter logic [7:0] RSVD6      = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        rd_req,
    output logic        rd_valid,
    output logic        rd_bit,
    output logic        sens_start,
    input  logic        sens_done,
    input  logic [15:0] sens_value,
    output logic        conv_busy,
    output logic        nv_busy,
    output logic        alarm
);
    phase_t       phase_q;
    logic [1:0]   widx_q;
    logic [7:0]   th_q, tl_q, cfg_q;
    logic         any_busy, cmd_take;
    logic         conv_go, rd_go, copy_go, recall_go;
    logic         load_done;
    logic [15:0]  temp;
    trip_t        nv_mem;
    logic [63:0]  body;
    logic [SP_BITS-1:0] image;

    assign any_busy  = conv_busy | nv_busy;
    assign cmd_take  = byte_valid && !bus_reset && (phase_q == PH_CMD) && !any_busy;
    assign conv_go   = cmd_take && (byte_data == OP_CONVERT);
    assign rd_go     = cmd_take && (byte_data == OP_RDSP);
    assign copy_go   = cmd_take && (byte_data == OP_COPY);
    assign recall_go = cmd_take && (byte_data == OP_RECALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CMD;
            widx_q  <= '0;
            th_q    <= '0;
            tl_q    <= '0;
            cfg_q   <= 8'h7F;
        end else begin
            if (load_done) begin
                th_q  <= nv_mem.th;
                tl_q  <= nv_mem.tl;
                cfg_q <= cfg_fix(nv_mem.cfg);
            end
            if (bus_reset) begin
                phase_q <= PH_CMD;
            end else if (cmd_take) begin
                widx_q  <= '0;
                phase_q <= (byte_data == OP_WRSP) ? PH_WRITE : PH_HOLD;
            end else if (phase_q == PH_WRITE && byte_valid) begin
                case (widx_q)
                    2'd0:    th_q  <= byte_data;
                    2'd1:    tl_q  <= byte_data;
                    default: cfg_q <= cfg_fix(byte_data);
                endcase
                widx_q <= widx_q + 1'b1;
                if (widx_q == 2'd2) phase_q <= PH_HOLD;
            end
        end
    end

    assign body  = {8'h10, RSVD6, 8'hFF, cfg_q, tl_q, th_q, temp};
    assign image = {crc8_lsb(body), body};

    tsense_conv #(.CONV_TICKS(CONV_TICKS)) u_conv (
        .clk(clk), .rst(rst), .start(conv_go), .res(cfg_q[6:5]),
        .th(th_q), .tl(tl_q), .sens_done(sens_done), .sens_value(sens_value),
        .sens_start(sens_start), .busy(conv_busy), .temp(temp), .alarm(alarm)
    );

    tsense_nvm #(.NV_TICKS(NV_TICKS), .TH0(NV_TH), .TL0(NV_TL), .CFG0(NV_CFG)) u_nvm (
        .clk(clk), .rst(rst), .store_req(copy_go),
        .store_data('{th: th_q, tl: tl_q, cfg: cfg_q}),
        .load_req(recall_go), .busy(nv_busy), .mem(nv_mem), .load_done(load_done)
    );

    tsense_rd u_rd (
        .clk(clk), .rst(rst), .arm_data(rd_go), .arm_stat(recall_go),
        .stop(bus_reset), .stat_bit(!nv_busy), .rd_req(rd_req), .image(image),
        .rd_valid(rd_valid), .rd_bit(rd_bit)
    );

    assert_cfg_rsv_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[7] == 1'b0) && (cfg_q[4:0] == 5'h1F));
    assert_ignore_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && conv_busy && phase_q == PH_CMD && !bus_reset)
        |=> ($stable(th_q) && $stable(tl_q) && $stable(cfg_q)));

endmodule

// File: tb/tsense_scratch_tb.sv
module tsense_scratch_tb;
    import tsense_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset = 1'b0, byte_valid = 1'b0, rd_req = 1'b0, sens_done = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [15:0] sens_value = '0;
    logic        rd_valid, rd_bit, sens_start, conv_busy, nv_busy, alarm;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    tsense_scratch u_dut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .byte_valid(byte_valid),
        .byte_data(byte_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_bit(rd_bit),
        .sens_start(sens_start), .sens_done(sens_done), .sens_value(sens_value),
        .conv_busy(conv_busy), .nv_busy(nv_busy), .alarm(alarm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] residue(input logic [71:0] d);
        logic [7:0] c = '0;
        logic fb;
        for (int i = 0; i < 72; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic busrst();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic rslot(output logic b, output logic v);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; b = rd_bit; v = rd_valid;
    endtask

    task automatic read_sp(output logic [71:0] img);
        logic b, v;
        busrst(); send(OP_RDSP);
        for (int i = 0; i < 72; i++) begin rslot(b, v); img[i] = b; end
    endtask

    task automatic wait_idle();
        while (conv_busy || nv_busy) @(negedge clk);
    endtask

    task automatic write_sp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        busrst(); send(OP_WRSP); send(a); send(b); send(c);
    endtask

    task automatic do_convert(input logic [15:0] v, output int n);
        busrst(); send(OP_CONVERT);
        chk("R7 sens_start pulse", sens_start, 1'b1);
        n = 0;
        while (conv_busy) begin
            n++;
            if (n == 3) begin sens_done = 1'b1; sens_value = v; end
            else sens_done = 1'b0;
            @(negedge clk);
        end
        sens_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [71:0] img;
        logic b, v;
        chk("R1 nv_busy during load", nv_busy, 1'b1);
        chk("R1 conv idle", conv_busy, 1'b0);
        chk("R1 alarm clear", alarm, 1'b0);
        wait_idle();
        rslot(b, v);
        chk("R4 idle slot valid", v, 1'b1);
        chk("R4 idle slot reads 1", b, 1'b1);
        read_sp(img);
        chk("R1 temp power-up", img[15:0], 16'h0550);
        chk("R1 th loaded", img[23:16], 8'h46);
        chk("R1 tl loaded", img[31:24], 8'h0A);
        chk("R1 cfg loaded", img[39:32], 8'h7F);
        chk("R4 byte5", img[47:40], 8'hFF);
        chk("R4 byte6", img[55:48], 8'h00);
        chk("R4 byte7", img[63:56], 8'h10);
        chk("R5 crc residue", residue(img), 8'h00);
    endtask

    task automatic t_write();
        logic [71:0] img;
        write_sp(8'h19, 8'hF6, 8'hFF);
        read_sp(img);
        chk("R2 th written", img[23:16], 8'h19);
        chk("R2 tl written", img[31:24], 8'hF6);
        chk("R3 cfg reserved bits ff", img[39:32], 8'h7F);
        chk("R5 crc after write", residue(img), 8'h00);
        write_sp(8'h19, 8'hF6, 8'h00);
        read_sp(img);
        chk("R3 cfg reserved bits 00", img[39:32], 8'h1F);
        write_sp(8'h19, 8'hF6, 8'h7F);
    endtask

    task automatic t_conv12();
        logic [71:0] img;
        int n;
        do_convert(16'h0191, n);
        chk("R7 12-bit length", n, 64);
        read_sp(img);
        chk("R7 temp stored", img[15:0], 16'h0191);
        chk("R9 alarm at th bound", alarm, 1'b1);
        chk("R5 crc after conversion", residue(img), 8'h00);
    endtask

    task automatic t_alarm();
        int n;
        do_convert(16'h0180, n);
        chk("R9 inside window", alarm, 1'b0);
        do_convert(16'hFF60, n);
        chk("R9 at tl bound", alarm, 1'b1);
        do_convert(16'hFF70, n);
        chk("R9 just above tl", alarm, 1'b0);
        do_convert(16'h0800, n);
        chk("R9 bits 11..4 signed", alarm, 1'b1);
    endtask

    task automatic t_res();
        logic [71:0] img;
        int n;
        write_sp(8'h19, 8'hF6, 8'h1F);
        do_convert(16'h0197, n);
        read_sp(img);
        chk("R7 9-bit length", n, 8);
        chk("R8 9-bit mask", img[15:0], 16'h0190);
        write_sp(8'h19, 8'hF6, 8'h3F);
        do_convert(16'h0197, n);
        read_sp(img);
        chk("R7 10-bit length", n, 16);
        chk("R8 10-bit mask", img[15:0], 16'h0194);
        write_sp(8'h19, 8'hF6, 8'h5F);
        do_convert(16'h0197, n);
        read_sp(img);
        chk("R7 11-bit length", n, 32);
        chk("R8 11-bit mask", img[15:0], 16'h0196);
        write_sp(8'h19, 8'hF6, 8'h7F);
    endtask

    task automatic t_partial();
        logic [71:0] img;
        busrst(); send(OP_WRSP); send(8'h55); busrst();
        read_sp(img);
        chk("R6 partial th kept", img[23:16], 8'h55);
        chk("R6 partial tl untouched", img[31:24], 8'hF6);
        chk("R6 partial cfg untouched", img[39:32], 8'h7F);
    endtask

    task automatic t_abort();
        logic [7:0] a, c;
        logic b, v;
        busrst(); send(OP_RDSP);
        for (int i = 0; i < 8; i++) begin rslot(b, v); a[i] = b; end
        busrst(); send(OP_RDSP);
        for (int i = 0; i < 8; i++) begin rslot(b, v); c[i] = b; end
        chk("R6 read restarts at byte0", c, a);
        chk("R6 byte0 value", c, 8'h96);
    endtask

    task automatic t_tail();
        logic [71:0] img;
        logic b, v;
        logic [2:0] t;
        read_sp(img);
        for (int i = 0; i < 3; i++) begin rslot(b, v); t[i] = b; end
        chk("R4 past byte 8 reads 1", t, 3'b111);
    endtask

    task automatic t_busy();
        logic [71:0] img;
        busrst(); send(OP_CONVERT);
        busrst(); send(OP_WRSP); send(8'h22); send(8'h22); send(8'h22);
        chk("R12 still converting", conv_busy, 1'b1);
        wait_idle();
        read_sp(img);
        chk("R12 th unchanged", img[23:16], 8'h55);
        chk("R12 temp kept without sample", img[15:0], 16'h0196);
    endtask

    task automatic t_nv();
        logic [71:0] img;
        logic b, v;
        write_sp(8'h33, 8'h44, 8'h7F);
        busrst(); send(OP_COPY);
        chk("R10 copy busy", nv_busy, 1'b1);
        wait_idle();
        write_sp(8'h77, 8'h88, 8'h1F);
        busrst(); send(OP_RECALL);
        rslot(b, v);
        chk("R11 recall in progress", b, 1'b0);
        repeat (12) @(negedge clk);
        rslot(b, v);
        chk("R11 recall finished", b, 1'b1);
        read_sp(img);
        chk("R10 th restored", img[23:16], 8'h33);
        chk("R10 tl restored", img[31:24], 8'h44);
        chk("R10 cfg restored", img[39:32], 8'h7F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_conv12();
        t_alarm();
        t_res();
        t_partial();
        t_abort();
        t_tail();
        t_busy();
        t_nv();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule